// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This block resolves a single instruction operand. It takes a mode code, two register selectors (base and index), a 16-bit constant field and a flag that says whether the operand is a destination. From these it forms the effective address, fetches the operand value, and reports completion with a one-cycle done pulse. Register contents arrive through two combinational read ports of an external register file. Memory is reached through one read port that uses a request/valid handshake. The unit drives a register write port only to update the base register in the two auto-step modes.

A pipeline or a multi-cycle core uses the unit once per operand. It raises `start_i` with the operand fields and waits for `done_o`. The unit then holds `operand_o` and `eaddr_o` until the next operand is accepted. `err_o` rises together with `done_o` for a mode code that is not defined, and for a constant operand that is used as a destination. In both of those cases the unit makes no memory access and no register write.

Top module: `opnd_addr_unit`

## Requirements
- R1: While reset is held, and right after it, `done_o`, `err_o`, `mem_req_o` and `rf_we_o` are all low.
- R2: Mode 0 (immediate) used as a source returns `const_i` as the operand. `eaddr_o` is 0. There is no memory request, and `done_o` rises in the cycle after the start cycle.
- R3: Mode 0 with `is_dst_i`=1 completes in the cycle after the start cycle with `err_o`=1, `operand_o`=0 and `eaddr_o`=0. There is no memory request and no register write.
- R4: Mode 1 (register) returns the content of the base register. `eaddr_o` is 0. There is no memory request, and `done_o` rises in the cycle after the start cycle.
- R5: Mode 2 (direct) uses `const_i` as the effective address and returns the memory word at that address, with exactly one read.
- R6: Mode 3 (register indirect) uses the base register content as the effective address and returns the memory word at that address.
- R7: Mode 4 (indexed) uses base plus index register contents, modulo 2^16, as the effective address.
- R8: Mode 5 (displacement) uses `const_i` plus the base register content, modulo 2^16, as the effective address.
- R9: Mode 6 (memory indirect) issues two reads in order. The first read is at the base register content. The second read is at the word returned by the first. `eaddr_o` is that pointer word, and the operand is the second word.
- R10: Mode 7 (post-increment) uses the old base value as the effective address. In the done cycle it writes base+STEP (STEP=2, modulo 2^16) into the base register, and that is the only register write.
- R11: Mode 8 (pre-decrement) uses base-STEP as the effective address and writes that same value back into the base register in the done cycle.
- R12: Mode codes 9 to 15 complete in the cycle after the start cycle with `err_o`=1, with no memory request and no register write.
- R13: A memory request stays high, with a stable address, until `mem_rvalid_i` is seen in a request cycle. `done_o` rises in the cycle after the last accepted response, lasts one cycle, and is never high together with a request.
- R14: A `start_i` that arrives while an operand is in progress is ignored. It does not change the result, add memory reads, or produce an extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin resolving an operand (taken only when idle) |
| mode_i | input | 4 | Addressing mode code |
| is_dst_i | input | 1 | Operand is a destination |
| base_sel_i | input | 3 | Base register selector |
| idx_sel_i | input | 3 | Index register selector |
| const_i | input | 16 | Immediate, absolute address or displacement |
| rf_a_addr_o | output | 3 | Register read port A address (base) |
| rf_a_data_i | input | 16 | Register read port A data |
| rf_b_addr_o | output | 3 | Register read port B address (index) |
| rf_b_data_i | input | 16 | Register read port B data |
| rf_we_o | output | 1 | Base register write enable |
| rf_waddr_o | output | 3 | Register write address |
| rf_wdata_o | output | 16 | Register write data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rvalid_i | input | 1 | Memory read response valid |
| mem_rdata_i | input | 16 | Memory read data |
| operand_o | output | 16 | Resolved operand value |
| eaddr_o | output | 16 | Effective address |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Illegal mode or immediate destination, valid with done |

## Verification
Every one of the sixteen mode codes is swept in both the source and the destination role. The sweep runs over four register and constant patterns and two memory latencies. The patterns put 0x0000, 0x0001, 0x7FFF and 0xFFFF into base and index registers, and constants near both ends of the range. This separates correct modulo wrap in the indexed, displacement, increment and decrement sums from a truncated or sign-extended sum. Running the same base and index register through the sweep shows whether both read ports are wired correctly. A memory model whose data depends on its address, together with a log of read addresses, separates a correct two-step pointer fetch from one that reuses the first address. A zero-latency and a three-cycle-latency memory expose whether the done timing counts responses or cycles. A second start injected in the middle of a slow operand shows whether a busy unit really ignores it.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] AM_IMM  = 4'd0;
  localparam logic [MODE_W-1:0] AM_REG  = 4'd1;
  localparam logic [MODE_W-1:0] AM_DIR  = 4'd2;
  localparam logic [MODE_W-1:0] AM_RIND = 4'd3;
  localparam logic [MODE_W-1:0] AM_IDX  = 4'd4;
  localparam logic [MODE_W-1:0] AM_DISP = 4'd5;
  localparam logic [MODE_W-1:0] AM_MIND = 4'd6;
  localparam logic [MODE_W-1:0] AM_AINC = 4'd7;
  localparam logic [MODE_W-1:0] AM_ADEC = 4'd8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_DONE
  } st_e;

  typedef struct packed {
    logic reject;
    logic uses_mem;
    logic two_reads;
    logic auto_step;
  } mode_info_t;
endpackage

// File: rtl/oam_mode_dec.sv
module oam_mode_dec
  import opnd_addr_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              is_dst_i,
  output mode_info_t        info_o
);
  logic legal;

  always_comb begin
    legal            = 1'b1;
    info_o.uses_mem  = 1'b0;
    info_o.two_reads = 1'b0;
    info_o.auto_step = 1'b0;
    unique case (mode_i)
      AM_IMM, AM_REG: ;
      AM_DIR, AM_RIND, AM_IDX, AM_DISP: info_o.uses_mem = 1'b1;
      AM_MIND: begin
        info_o.uses_mem  = 1'b1;
        info_o.two_reads = 1'b1;
      end
      AM_AINC, AM_ADEC: begin
        info_o.uses_mem  = 1'b1;
        info_o.auto_step = 1'b1;
      end
      default: legal = 1'b0;
    endcase
    // constants can never be written
    info_o.reject = !legal || (mode_i == AM_IMM && is_dst_i);
  end
endmodule

// File: rtl/oam_ea_calc.sv
module oam_ea_calc
  import opnd_addr_pkg::*;
#(
  parameter int DW   = 16,
  parameter int STEP = 2
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DW-1:0]     base_i,
  input  logic [DW-1:0]     idx_i,
  input  logic [DW-1:0]     cst_i,
  output logic [DW-1:0]     ea_o,
  output logic [DW-1:0]     wb_o,
  output logic [DW-1:0]     direct_o
);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  logic [DW-1:0] base_inc;
  logic [DW-1:0] base_dec;

  assign base_inc = base_i + STEP_V;
  assign base_dec = base_i - STEP_V;

  always_comb begin
    unique case (mode_i)
      AM_DIR:                     ea_o = cst_i;
      AM_RIND, AM_MIND, AM_AINC:  ea_o = base_i;
      AM_IDX:                     ea_o = base_i + idx_i;
      AM_DISP:                    ea_o = cst_i + base_i;
      AM_ADEC:                    ea_o = base_dec;
      default:                    ea_o = '0;
    endcase
  end

  assign wb_o = (mode_i == AM_AINC) ? base_inc : base_dec;

  always_comb begin
    unique case (mode_i)
      AM_IMM:  direct_o = cst_i;
      AM_REG:  direct_o = base_i;
      default: direct_o = '0;
    endcase
  end
endmodule

// File: rtl/oam_ctrl.sv
module oam_ctrl
  import opnd_addr_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RIDX_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mode_info_t        info_i,
  input  logic [DW-1:0]     ea_i,
  input  logic [DW-1:0]     wb_i,
  input  logic [DW-1:0]     direct_i,
  input  logic [RIDX_W-1:0] base_sel_i,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              mem_req_o,
  output logic [DW-1:0]     mem_addr_o,
  output logic              rf_we_o,
  output logic [RIDX_W-1:0] rf_waddr_o,
  output logic [DW-1:0]     rf_wdata_o,
  output logic [DW-1:0]     operand_o,
  output logic [DW-1:0]     eaddr_o,
  output logic              done_o,
  output logic              err_o,
  output logic              busy_o
);
  st_e               st_q;
  logic [DW-1:0]     addr_q;
  logic [DW-1:0]     opnd_q;
  logic [DW-1:0]     wb_q;
  logic [RIDX_W-1:0] wsel_q;
  logic              err_q;
  logic              auto_q;
  logic              two_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      opnd_q <= '0;
      wb_q   <= '0;
      wsel_q <= '0;
      err_q  <= 1'b0;
      auto_q <= 1'b0;
      two_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          wb_q   <= wb_i;
          wsel_q <= base_sel_i;
          err_q  <= info_i.reject;
          if (info_i.reject) begin
            addr_q <= '0;
            opnd_q <= '0;
            auto_q <= 1'b0;
            two_q  <= 1'b0;
            st_q   <= ST_DONE;
          end else if (info_i.uses_mem) begin
            addr_q <= ea_i;
            auto_q <= info_i.auto_step;
            two_q  <= info_i.two_reads;
            st_q   <= ST_RD1;
          end else begin
            addr_q <= ea_i;
            opnd_q <= direct_i;
            auto_q <= 1'b0;
            two_q  <= 1'b0;
            st_q   <= ST_DONE;
          end
        end
        ST_RD1: if (mem_rvalid_i) begin
          if (two_q) begin
            // pointer word becomes the effective address
            addr_q <= mem_rdata_i;
            st_q   <= ST_RD2;
          end else begin
            opnd_q <= mem_rdata_i;
            st_q   <= ST_DONE;
          end
        end
        ST_RD2: if (mem_rvalid_i) begin
          opnd_q <= mem_rdata_i;
          st_q   <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == ST_RD1) || (st_q == ST_RD2);
  assign mem_addr_o = addr_q;
  assign done_o     = (st_q == ST_DONE);
  assign err_o      = done_o && err_q;
  assign rf_we_o    = done_o && auto_q;
  assign rf_waddr_o = wsel_q;
  assign rf_wdata_o = wb_q;
  assign operand_o  = opnd_q;
  assign eaddr_o    = addr_q;
  assign busy_o     = (st_q != ST_IDLE);
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import opnd_addr_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int STEP = 2,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              is_dst_i,
  input  logic [RIDX_W-1:0] base_sel_i,
  input  logic [RIDX_W-1:0] idx_sel_i,
  input  logic [DW-1:0]     const_i,
  output logic [RIDX_W-1:0] rf_a_addr_o,
  input  logic [DW-1:0]     rf_a_data_i,
  output logic [RIDX_W-1:0] rf_b_addr_o,
  input  logic [DW-1:0]     rf_b_data_i,
  output logic              rf_we_o,
  output logic [RIDX_W-1:0] rf_waddr_o,
  output logic [DW-1:0]     rf_wdata_o,
  output logic              mem_req_o,
  output logic [DW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic [DW-1:0]     operand_o,
  output logic [DW-1:0]     eaddr_o,
  output logic              done_o,
  output logic              err_o
);
  mode_info_t    info;
  logic [DW-1:0] ea;
  logic [DW-1:0] wb;
  logic [DW-1:0] direct;
  logic          busy;

  assign rf_a_addr_o = base_sel_i;
  assign rf_b_addr_o = idx_sel_i;

  oam_mode_dec u_dec (
    .mode_i   (mode_i),
    .is_dst_i (is_dst_i),
    .info_o   (info)
  );

  oam_ea_calc #(.DW(DW), .STEP(STEP)) u_ea (
    .mode_i   (mode_i),
    .base_i   (rf_a_data_i),
    .idx_i    (rf_b_data_i),
    .cst_i    (const_i),
    .ea_o     (ea),
    .wb_o     (wb),
    .direct_o (direct)
  );

  oam_ctrl #(.DW(DW), .RIDX_W(RIDX_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .info_i       (info),
    .ea_i         (ea),
    .wb_i         (wb),
    .direct_i     (direct),
    .base_sel_i   (base_sel_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .rf_we_o      (rf_we_o),
    .rf_waddr_o   (rf_waddr_o),
    .rf_wdata_o   (rf_wdata_o),
    .operand_o    (operand_o),
    .eaddr_o      (eaddr_o),
    .done_o       (done_o),
    .err_o        (err_o),
    .busy_o       (busy)
  );
endmodule

// File: rtl/opnd_addr_unit_chk.sv
module opnd_addr_unit_chk
  import opnd_addr_pkg::*;
#(
  parameter int DW = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              is_dst_i,
  input logic              busy,
  input logic              mem_req_o,
  input logic              mem_rvalid_i,
  input logic [DW-1:0]     mem_addr_o,
  input logic              done_o,
  input logic              err_o,
  input logic              rf_we_o
);
  logic accept;
  assign accept = start_i && !busy;

  p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_req_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  p_req_not_done_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !done_o);

  p_imm_dst_rej_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && mode_i == AM_IMM && is_dst_i |=> done_o && err_o && !rf_we_o && !mem_req_o);

  p_illegal_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && mode_i > AM_ADEC |=> done_o && err_o && !rf_we_o && !mem_req_o);

  p_reg_fast_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && mode_i == AM_REG |=> done_o && !err_o && !mem_req_o);

  p_wb_clean_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> done_o && !err_o);

  p_busy_ignore_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && mem_req_o && !mem_rvalid_i |=> !done_o);
endmodule

bind opnd_addr_unit opnd_addr_unit_chk #(.DW(DW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .mode_i       (mode_i),
  .is_dst_i     (is_dst_i),
  .busy         (busy),
  .mem_req_o    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_addr_o   (mem_addr_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .rf_we_o      (rf_we_o)
);

// File: tb/tb_opnd_addr_unit.sv
module tb_opnd_addr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NREG = 8;
  localparam int STEP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic        is_dst = 1'b0;
  logic [2:0]  base_sel = '0;
  logic [2:0]  idx_sel = '0;
  logic [15:0] cst = '0;
  logic [2:0]  rf_a_addr, rf_b_addr, rf_waddr;
  logic [15:0] rf_a_data, rf_b_data, rf_wdata;
  logic        rf_we, mem_req, mem_rvalid, done, err;
  logic [15:0] mem_addr, mem_rdata, operand, eaddr;

  logic [15:0] regs [NREG];
  logic [15:0] rlog [8];
  int lat = 0;
  int cnt;
  int nlog;
  int nwr;
  int checks = 0;
  int fails = 0;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[6:0], a[15:7]} ^ 16'h3C5A;
  endfunction

  function automatic logic [15:0] reg_init(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0040;
      2: return 16'h1234;
      3: return 16'h0001;
      4: return 16'h8000;
      5: return 16'h7FFF;
      6: return 16'hABCD;
      default: return 16'hFFFF;
    endcase
  endfunction

  assign rf_a_data  = regs[rf_a_addr];
  assign rf_b_data  = regs[rf_b_addr];
  assign mem_rvalid = mem_req && (cnt == lat);
  assign mem_rdata  = memf(mem_addr);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reg_init(i);
      cnt  <= 0;
      nlog <= 0;
      nwr  <= 0;
    end else begin
      if (mem_req && !mem_rvalid) cnt <= cnt + 1;
      else cnt <= 0;
      if (mem_req && mem_rvalid) begin
        rlog[nlog % 8] <= mem_addr;
        nlog <= nlog + 1;
      end
      if (rf_we) begin
        regs[rf_waddr] <= rf_wdata;
        nwr <= nwr + 1;
      end
    end
  end

  opnd_addr_unit #(.DW(DW), .NREG(NREG), .STEP(STEP)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .mode_i       (mode),
    .is_dst_i     (is_dst),
    .base_sel_i   (base_sel),
    .idx_sel_i    (idx_sel),
    .const_i      (cst),
    .rf_a_addr_o  (rf_a_addr),
    .rf_a_data_i  (rf_a_data),
    .rf_b_addr_o  (rf_b_addr),
    .rf_b_data_i  (rf_b_data),
    .rf_we_o      (rf_we),
    .rf_waddr_o   (rf_waddr),
    .rf_wdata_o   (rf_wdata),
    .mem_req_o    (mem_req),
    .mem_addr_o   (mem_addr),
    .mem_rvalid_i (mem_rvalid),
    .mem_rdata_i  (mem_rdata),
    .operand_o    (operand),
    .eaddr_o      (eaddr),
    .done_o       (done),
    .err_o        (err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  function automatic string mtag(input logic [3:0] m, input logic d);
    case (m)
      4'd0: return d ? "R3" : "R2";
      4'd1: return "R4";
      4'd2: return "R5";
      4'd3: return "R6";
      4'd4: return "R7";
      4'd5: return "R8";
      4'd6: return "R9";
      4'd7: return "R10";
      4'd8: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic run_op(input logic [3:0] m, input logic d, input logic [2:0] b,
                        input logic [2:0] x, input logic [15:0] c, input bit inj);
    logic [15:0] er [NREG];
    logic [15:0] rb, ri, e_op, e_ea, ra0, ra1, ptr;
    bit e_err, e_auto;
    int nrd, e_cyc, cyc, n0, w0;
    string tg;
    for (int i = 0; i < NREG; i++) er[i] = regs[i];
    rb = regs[b]; ri = regs[x];
    e_err = 0; e_auto = 0; nrd = 0; e_op = '0; e_ea = '0; ra0 = '0; ra1 = '0;
    case (m)
      4'd0: if (d) e_err = 1; else e_op = c;
      4'd1: e_op = rb;
      4'd2: begin e_ea = c; nrd = 1; end
      4'd3: begin e_ea = rb; nrd = 1; end
      4'd4: begin e_ea = rb + ri; nrd = 1; end
      4'd5: begin e_ea = c + rb; nrd = 1; end
      4'd6: begin ptr = memf(rb); ra0 = rb; e_ea = ptr; nrd = 2; end
      4'd7: begin e_ea = rb; nrd = 1; e_auto = 1; er[b] = rb + 16'(STEP); end
      4'd8: begin e_ea = rb - 16'(STEP); nrd = 1; e_auto = 1; er[b] = e_ea; end
      default: e_err = 1;
    endcase
    if (nrd > 0) e_op = memf(e_ea);
    if (nrd == 1) ra0 = e_ea;
    if (nrd == 2) ra1 = e_ea;
    e_cyc = 1 + nrd * (lat + 1);
    tg = mtag(m, d);
    n0 = nlog; w0 = nwr;

    start = 1'b1; mode = m; is_dst = d; base_sel = b; idx_sel = x; cst = c;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 60) begin
      if (inj && cyc == 1) begin
        start = 1'b1; mode = 4'd0; is_dst = 1'b0; cst = 16'h5555;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    chk(cyc == e_cyc, "R13 done latency", 32'(cyc), 32'(e_cyc));
    chk(done == 1'b1, {tg, " done"}, 32'(done), 1);
    chk(err == e_err, {tg, " err"}, 32'(err), 32'(e_err));
    chk(operand == e_op, {tg, " operand"}, 32'(operand), 32'(e_op));
    chk(eaddr == e_ea, {tg, " eaddr"}, 32'(eaddr), 32'(e_ea));
    @(negedge clk);
    chk(!done, "R13 done single cycle", 32'(done), 0);
    chk(nlog - n0 == nrd, {tg, " read count"}, 32'(nlog - n0), 32'(nrd));
    if (nrd >= 1) chk(rlog[n0 % 8] == ra0, {tg, " first read addr"}, 32'(rlog[n0 % 8]), 32'(ra0));
    if (nrd == 2) chk(rlog[(n0 + 1) % 8] == ra1, "R9 second read addr",
                      32'(rlog[(n0 + 1) % 8]), 32'(ra1));
    chk(nwr - w0 == int'(e_auto), {tg, " write count"}, 32'(nwr - w0), 32'(e_auto));
    for (int i = 0; i < NREG; i++)
      chk(regs[i] == er[i], {tg, " regfile"}, 32'(regs[i]), 32'(er[i]));
    if (inj) begin
      @(negedge clk);
      chk(!done, "R14 ignored start", 32'(done), 0);
      chk(nlog - n0 == nrd, "R14 no extra read", 32'(nlog - n0), 32'(nrd));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [2:0]  pb, px;
    logic [15:0] pc;
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!done && !err && !mem_req && !rf_we, "R1 reset outputs",
        {28'd0, done, err, mem_req, rf_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !err && !mem_req && !rf_we, "R1 after reset",
        {28'd0, done, err, mem_req, rf_we}, 0);

    for (int p = 0; p < 4; p++) begin
      case (p)
        0: begin pb = 3'd1; px = 3'd2; pc = 16'h0040; end
        1: begin pb = 3'd7; px = 3'd5; pc = 16'hFFF0; end
        2: begin pb = 3'd0; px = 3'd0; pc = 16'h8000; end
        default: begin pb = 3'd3; px = 3'd7; pc = 16'h0001; end
      endcase
      for (int li = 0; li < 2; li++) begin
        lat = (li == 0) ? 0 : 2;
        for (int m = 0; m < 16; m++)
          for (int d = 0; d < 2; d++)
            run_op(4'(m), 1'(d), pb, px, pc, 1'b0);
      end
    end

    // R14: second start during slow memory fetches
    lat = 3;
    run_op(4'd2, 1'b0, 3'd1, 3'd2, 16'h0123, 1'b1);
    run_op(4'd6, 1'b0, 3'd4, 3'd2, 16'h0000, 1'b1);
    run_op(4'd7, 1'b0, 3'd6, 3'd2, 16'h0000, 1'b1);

    summary();
    $finish;
  end
endmodule